// File: doc/BRIEF.md
# Multi-Channel Block DMA Engine

This block copies bytes between a wide system bus (an 8-bit bank plus a 16-bit offset, called the A side here) and a narrow peripheral window (a 256-byte page at 0x2100, called the B side) for up to eight channels. A start pulse together with a channel mask arms channels. The engine then serves every armed channel once, lowest index first, moving one byte per 8-clock slot until that channel's byte count runs out or its enable bit is withdrawn.

Each channel supplies a direction, a 3-bit mode, a B-side base byte, a bank, a 16-bit offset, a fixed-address flag, a decrement flag and a 16-bit count. The mode decides how the B-side address steps through a group of up to four bytes. Some A-side regions (the peripheral window itself and the I/O page) are never touched. A read from any of them yields zero. Moving bytes between the work-RAM area and B byte 0x80 is also refused on the B side. The register file that holds the settings, and arbitration with a processor, sit outside this block.

Top module: `dma_engine`

## Requirements
- R1: Timing. `busy` rises in the cycle after `start` is sampled. An 8-cycle preamble is followed, for each served channel, by an 8-cycle channel preamble and then 8 cycles per byte. Within a byte slot the read strobe is in its 4th cycle, the read data is taken in its 5th cycle, and the write strobe is in its 8th (last) cycle. At most one strobe is high in any cycle.
- R2: Channels whose bit is set in `chanEnable` are served in ascending index order. Channels without the bit are not served.
- R3: The B address is {0x21, base + k}. The byte index is i (0..3). Modes 1 and 5 use k = i[0]. Modes 3 and 7 use k = i[1]. Mode 4 uses k = i. Modes 0, 2 and 6 use k = 0.
- R4: The byte index starts at 0 whenever a channel begins and wraps modulo 4.
- R5: After each byte the 16-bit offset rises by one. It falls by one when the decrement flag is set, and stays put when the fixed flag is set. It wraps within 16 bits and the bank never changes.
- R6: Direction 0 reads the A side and writes the B side. Direction 1 reads the B side and writes the A side. The written data equals the byte read.
- R7: When bank bit 6 is 0, A offsets 0x2100-0x21FF, 0x4000-0x41FF, 0x4200-0x421F and 0x4300-0x437F are refused. No strobe is raised for them, and a refused read yields 0x00.
- R8: The B side is refused when the B address low byte is 0x80 and either the bank is 0x7E or 0x7F, or bank bit 6 is 0 with an offset below 0x2000. No B strobe is raised, and a refused B read yields 0x00.
- R9: A channel stops after the byte during which its count reaches zero. The count is decremented per byte, so a starting count of 0 means 65536 bytes.
- R10: `chanEnable` bit n (channel n) is set by `startMask` bit n at start and clears when channel n finishes.
- R11: An `enableClr` bit clears the matching enable. If that channel is moving bytes, the byte in progress completes and no further byte follows. If the clear lands during the channel preamble, exactly one byte moves. A channel cleared before it begins is skipped.
- R12: After the last channel, `busy` stays low for one cycle in which `start` is ignored. A start is accepted only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only when idle |
| startMask | input | NCH | Channels to arm at start |
| enableClr | input | NCH | Withdraws channel enables |
| cfgDir | input | NCH | Per-channel direction |
| cfgMode | input | NCH x 3 | Per-channel B address pattern |
| cfgTarget | input | NCH x 8 | Per-channel B base byte |
| cfgBank | input | NCH x 8 | Per-channel A bank |
| cfgAddr | input | NCH x 16 | Per-channel A start offset |
| cfgFixed | input | NCH | Keep the A offset constant |
| cfgReverse | input | NCH | Decrement the A offset |
| cfgCount | input | NCH x 16 | Byte count (0 means 65536) |
| aAddr | output | 24 | A-side address {bank, offset} |
| aRead | output | 1 | A read strobe, data expected next cycle |
| aWrite | output | 1 | A write strobe |
| aWdata | output | 8 | A write data |
| aRdata | input | 8 | A read data |
| bAddr | output | 16 | B-side address |
| bRead | output | 1 | B read strobe, data expected next cycle |
| bWrite | output | 1 | B write strobe |
| bWdata | output | 8 | B write data |
| bRdata | input | 8 | B read data |
| busy | output | 1 | Engine running |
| chanEnable | output | NCH | Armed channels |

## Verification
A wrong byte index, offset or count shows at the very next write strobe as a wrong address or data. It can also appear as a write that lands 8 cycles early or late, or that is missing. Every write is compared against an expected address, datum and exact cycle. A bad channel pick or a misplaced abort decision changes the order or count of writes within one channel preamble. A stuck state machine shows as `busy` falling at the wrong cycle or `chanEnable` not clearing when a channel ends. A masking fault raises a strobe inside a refused region in the same cycle, or writes a value other than zero.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int BANK_W = 8;
  localparam int OFS_W  = 16;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;
  localparam int PH_W   = 3;   // 8 clocks per slot
  localparam int IDX_W  = 2;   // byte index within a group

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_CHOV, ST_XFER, ST_REST
  } dmaState_t;

  typedef struct packed {
    logic             loadChan;
    logic             rdPulse;
    logic             capture;
    logic             wrPulse;
    logic [IDX_W-1:0] idx;
  } dmaStrobe_t;
endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [NCH-1:0] startMask,
  input  logic [NCH-1:0] enableClr,
  input  logic           countIsOne,
  output dmaStrobe_t     strb,
  output logic [CHW-1:0] chanSel,
  output logic           busy,
  output logic [NCH-1:0] chanEnable
);
  dmaState_t        state;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] byteIdx;
  logic             phEnd;
  logic             lastByte;
  logic             anyLeft;
  logic [NCH-1:0]   enKept;
  logic [NCH-1:0]   enAfter;
  logic [CHW-1:0]   nextSel;

  function automatic logic [CHW-1:0] lowestSet(input logic [NCH-1:0] v);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) r = CHW'(i);
    end
    return r;
  endfunction

  always_comb begin
    phEnd    = (phase == {PH_W{1'b1}});
    enKept   = chanEnable & ~enableClr;
    lastByte = (state == ST_XFER) && phEnd && (countIsOne || !enKept[chanSel]);
    enAfter  = enKept;
    if (lastByte) enAfter[chanSel] = 1'b0;
    if (state == ST_IDLE && start) enAfter = enAfter | startMask;
    anyLeft  = |enAfter;
    nextSel  = lowestSet(enAfter);
  end

  always_comb begin
    strb.loadChan = (state == ST_CHOV) && phEnd;
    strb.rdPulse  = (state == ST_XFER) && (phase == PH_W'(3));
    strb.capture  = (state == ST_XFER) && (phase == PH_W'(4));
    strb.wrPulse  = (state == ST_XFER) && phEnd;
    strb.idx      = byteIdx;
    busy          = (state == ST_INIT) || (state == ST_CHOV) || (state == ST_XFER);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= '0;
      chanSel    <= '0;
      byteIdx    <= '0;
      chanEnable <= '0;
    end else begin
      chanEnable <= enAfter;
      if (busy) phase <= phase + PH_W'(1);
      else      phase <= '0;
      case (state)
        ST_IDLE: if (start) state <= ST_INIT;
        ST_INIT: begin
          if (phEnd) begin
            if (anyLeft) begin
              state   <= ST_CHOV;
              chanSel <= nextSel;
            end else begin
              state <= ST_REST;
            end
          end
        end
        ST_CHOV: begin
          if (phEnd) begin
            state   <= ST_XFER;
            byteIdx <= '0;
          end
        end
        ST_XFER: begin
          if (phEnd) begin
            byteIdx <= byteIdx + IDX_W'(1);
            if (lastByte) begin
              if (anyLeft) begin
                state   <= ST_CHOV;
                chanSel <= nextSel;
              end else begin
                state <= ST_REST;
              end
            end
          end
        end
        ST_REST: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_path.sv
module dma_path
  import dma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dmaStrobe_t                      strb,
  input  logic [CHW-1:0]                  chanSel,
  input  logic [NCH-1:0]                  cfgDir,
  input  logic [NCH-1:0][MODE_W-1:0]      cfgMode,
  input  logic [NCH-1:0][DATA_W-1:0]      cfgTarget,
  input  logic [NCH-1:0][BANK_W-1:0]      cfgBank,
  input  logic [NCH-1:0][OFS_W-1:0]       cfgAddr,
  input  logic [NCH-1:0]                  cfgFixed,
  input  logic [NCH-1:0]                  cfgReverse,
  input  logic [NCH-1:0][OFS_W-1:0]       cfgCount,
  output logic [BANK_W+OFS_W-1:0]         aAddr,
  output logic                            aRead,
  output logic                            aWrite,
  output logic [DATA_W-1:0]               aWdata,
  input  logic [DATA_W-1:0]               aRdata,
  output logic [15:0]                     bAddr,
  output logic                            bRead,
  output logic                            bWrite,
  output logic [DATA_W-1:0]               bWdata,
  input  logic [DATA_W-1:0]               bRdata,
  output logic                            countIsOne
);
  logic              curDir;
  logic [MODE_W-1:0] curMode;
  logic [DATA_W-1:0] curTarget;
  logic [BANK_W-1:0] curBank;
  logic [OFS_W-1:0]  curOfs;
  logic              curFixed;
  logic              curRev;
  logic [OFS_W-1:0]  curCount;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] stepB;
  logic [DATA_W-1:0] bByte;
  logic              aOk;
  logic              bOk;
  logic              inIoHole;

  always_comb begin
    case (curMode)
      3'd1, 3'd5: stepB = DATA_W'(strb.idx[0]);
      3'd3, 3'd7: stepB = DATA_W'(strb.idx[1]);
      3'd4:       stepB = DATA_W'(strb.idx);
      default:    stepB = '0;
    endcase
    bByte    = curTarget + stepB;
    inIoHole = (curOfs[15:8] == 8'h21) || (curOfs[15:9] == 7'h20) ||
               (curOfs[15:5] == 11'h210) || (curOfs[15:7] == 9'h086);
    aOk      = curBank[6] || !inIoHole;
    bOk      = !((bByte == 8'h80) &&
                 ((curBank[7:1] == 7'h3F) || (!curBank[6] && (curOfs < 16'h2000))));
    aAddr      = {curBank, curOfs};
    bAddr      = {8'h21, bByte};
    aRead      = strb.rdPulse && !curDir && aOk;
    bRead      = strb.rdPulse &&  curDir && bOk;
    aWrite     = strb.wrPulse &&  curDir && aOk;
    bWrite     = strb.wrPulse && !curDir && bOk;
    aWdata     = dataReg;
    bWdata     = dataReg;
    countIsOne = (curCount == OFS_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDir    <= 1'b0;
      curMode   <= '0;
      curTarget <= '0;
      curBank   <= '0;
      curOfs    <= '0;
      curFixed  <= 1'b0;
      curRev    <= 1'b0;
      curCount  <= '0;
      dataReg   <= '0;
    end else begin
      if (strb.loadChan) begin
        curDir    <= cfgDir[chanSel];
        curMode   <= cfgMode[chanSel];
        curTarget <= cfgTarget[chanSel];
        curBank   <= cfgBank[chanSel];
        curOfs    <= cfgAddr[chanSel];
        curFixed  <= cfgFixed[chanSel];
        curRev    <= cfgReverse[chanSel];
        curCount  <= cfgCount[chanSel];
      end
      if (strb.capture) begin
        if (curDir) dataReg <= bOk ? bRdata : '0;
        else        dataReg <= aOk ? aRdata : '0;
      end
      if (strb.wrPulse) begin
        curCount <= curCount - OFS_W'(1);
        if (!curFixed) curOfs <= curRev ? curOfs - OFS_W'(1) : curOfs + OFS_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [NCH-1:0]              startMask,
  input  logic [NCH-1:0]              enableClr,
  input  logic [NCH-1:0]              cfgDir,
  input  logic [NCH-1:0][MODE_W-1:0]  cfgMode,
  input  logic [NCH-1:0][DATA_W-1:0]  cfgTarget,
  input  logic [NCH-1:0][BANK_W-1:0]  cfgBank,
  input  logic [NCH-1:0][OFS_W-1:0]   cfgAddr,
  input  logic [NCH-1:0]              cfgFixed,
  input  logic [NCH-1:0]              cfgReverse,
  input  logic [NCH-1:0][OFS_W-1:0]   cfgCount,
  output logic [BANK_W+OFS_W-1:0]     aAddr,
  output logic                        aRead,
  output logic                        aWrite,
  output logic [DATA_W-1:0]           aWdata,
  input  logic [DATA_W-1:0]           aRdata,
  output logic [15:0]                 bAddr,
  output logic                        bRead,
  output logic                        bWrite,
  output logic [DATA_W-1:0]           bWdata,
  input  logic [DATA_W-1:0]           bRdata,
  output logic                        busy,
  output logic [NCH-1:0]              chanEnable
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  dmaStrobe_t     strb;
  logic [CHW-1:0] chanSel;
  logic           countIsOne;

  dma_ctrl #(.NCH(NCH), .CHW(CHW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .startMask(startMask),
    .enableClr(enableClr), .countIsOne(countIsOne), .strb(strb),
    .chanSel(chanSel), .busy(busy), .chanEnable(chanEnable)
  );

  dma_path #(.NCH(NCH), .CHW(CHW)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .chanSel(chanSel),
    .cfgDir(cfgDir), .cfgMode(cfgMode), .cfgTarget(cfgTarget),
    .cfgBank(cfgBank), .cfgAddr(cfgAddr), .cfgFixed(cfgFixed),
    .cfgReverse(cfgReverse), .cfgCount(cfgCount),
    .aAddr(aAddr), .aRead(aRead), .aWrite(aWrite), .aWdata(aWdata),
    .aRdata(aRdata), .bAddr(bAddr), .bRead(bRead), .bWrite(bWrite),
    .bWdata(bWdata), .bRdata(bRdata), .countIsOne(countIsOne)
  );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           aRead,
  input logic           aWrite,
  input logic           bRead,
  input logic           bWrite,
  input logic [15:0]    aAddrHi,
  input logic [NCH-1:0] chanEnable
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(aRead || aWrite || bRead || bWrite));
  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({aRead, aWrite, bRead, bWrite}) <= 1);
  // R1
  read_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aRead || bRead) |=> !(aRead || bRead || aWrite || bWrite));
  // R12
  rest_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> !busy);
  // R12
  no_enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ((chanEnable & ~$past(chanEnable)) == '0));
  // R7
  masked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aWrite || aRead) |-> !(!aAddrHi[14] && (aAddrHi[7:0] == 8'h21)));
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .aRead(aRead), .aWrite(aWrite),
  .bRead(bRead), .bWrite(bWrite), .aAddrHi(aAddr[23:8]), .chanEnable(chanEnable)
);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  localparam int NCH = 8;

  typedef struct {
    bit          isB;
    logic [23:0] addr;
    logic [7:0]  data;
    int          cyc;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NCH-1:0] startMask = '0;
  logic [NCH-1:0] enableClr = '0;
  logic [NCH-1:0] cfgDir = '0;
  logic [NCH-1:0][2:0] cfgMode = '0;
  logic [NCH-1:0][7:0] cfgTarget = '0;
  logic [NCH-1:0][7:0] cfgBank = '0;
  logic [NCH-1:0][15:0] cfgAddr = '0;
  logic [NCH-1:0] cfgFixed = '0;
  logic [NCH-1:0] cfgReverse = '0;
  logic [NCH-1:0][15:0] cfgCount = '0;
  logic [23:0] aAddr;
  logic aRead, aWrite, bRead, bWrite, busy;
  logic [7:0] aWdata, bWdata;
  logic [7:0] aRdata = '0;
  logic [7:0] bRdata = '0;
  logic [15:0] bAddr;
  logic [NCH-1:0] chanEnable;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  item_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dma_engine #(.NCH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startMask(startMask),
    .enableClr(enableClr), .cfgDir(cfgDir), .cfgMode(cfgMode),
    .cfgTarget(cfgTarget), .cfgBank(cfgBank), .cfgAddr(cfgAddr),
    .cfgFixed(cfgFixed), .cfgReverse(cfgReverse), .cfgCount(cfgCount),
    .aAddr(aAddr), .aRead(aRead), .aWrite(aWrite), .aWdata(aWdata),
    .aRdata(aRdata), .bAddr(bAddr), .bRead(bRead), .bWrite(bWrite),
    .bWdata(bWdata), .bRdata(bRdata), .busy(busy), .chanEnable(chanEnable)
  );

  function automatic logic [7:0] aModel(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] bModel(input logic [7:0] b);
    return ~b ^ 8'h33;
  endfunction
  // R7 region rule
  function automatic bit okA(input logic [23:0] a);
    logic [15:0] o;
    o = a[15:0];
    if (a[22]) return 1'b1;
    return !((o >= 16'h2100 && o <= 16'h21FF) || (o >= 16'h4000 && o <= 16'h41FF) ||
             (o >= 16'h4200 && o <= 16'h421F) || (o >= 16'h4300 && o <= 16'h437F));
  endfunction
  // R8 work-RAM rule
  function automatic bit okB(input logic [7:0] b, input logic [23:0] a);
    if (b != 8'h80) return 1'b1;
    if (a[23:16] == 8'h7E || a[23:16] == 8'h7F) return 1'b0;
    if (!a[22] && a[15:0] < 16'h2000) return 1'b0;
    return 1'b1;
  endfunction
  // R3 pattern
  function automatic logic [7:0] bStep(input logic [2:0] m, input logic [1:0] i);
    case (m)
      3'd1, 3'd5: return {7'd0, i[0]};
      3'd3, 3'd7: return {7'd0, i[1]};
      3'd4:       return {6'd0, i};
      default:    return 8'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    aRdata <= aModel(aAddr);
    bRdata <= bModel(bAddr[7:0]);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes, checks read strobes against the refusal rules
  always @(negedge clk) begin
    if (rstN) begin
      if (aRead) check(okA(aAddr), "R7", "A read in refused region", aAddr, 0);
      if (bRead) check(okB(bAddr[7:0], aAddr), "R8", "B read refused", bAddr, 0);
      if (aWrite && bWrite) check(1'b0, "R1", "two write strobes", 1, 0);
      else if (aWrite || bWrite) begin
        if (expQ.size() == 0) check(1'b0, "R2", "unexpected write", aWrite ? aAddr : bAddr, 0);
        else begin
          item_t e;
          logic [23:0] ga;
          e = expQ.pop_front();
          ga = aWrite ? aAddr : {8'h00, bAddr};
          check(bWrite == e.isB, "R6", "write side", bWrite, e.isB);
          check(ga == e.addr, "R3/R5", "write address", ga, e.addr);
          check((aWrite ? aWdata : bWdata) == e.data, "R6/R7/R8", "write data",
                aWrite ? aWdata : bWdata, e.data);
          check(cyc == e.cyc, "R1", "write cycle", cyc, e.cyc);
        end
      end
    end
  end

  task automatic setChan(input int ch, input bit dir, input logic [2:0] mode,
                         input logic [7:0] tgt, input logic [7:0] bank,
                         input logic [15:0] addr, input bit fix, input bit rev,
                         input logic [15:0] cnt);
    cfgDir[ch] = dir; cfgMode[ch] = mode; cfgTarget[ch] = tgt; cfgBank[ch] = bank;
    cfgAddr[ch] = addr; cfgFixed[ch] = fix; cfgReverse[ch] = rev; cfgCount[ch] = cnt;
  endtask

  // driver: computes the expected write stream, starts the job, follows busy
  task automatic runJob(input logic [NCH-1:0] mask, input int abortRel,
                        input logic [NCH-1:0] abortMask);
    int s, t, abortAbs, tEnd;
    logic [NCH-1:0] rem;
    int endAt[NCH];
    logic [NCH-1:0] endVal[NCH];
    @(negedge clk);
    s = cyc + 1;
    abortAbs = (abortRel < 0) ? -1 : s + abortRel;
    t = s + 8;
    rem = mask;
    for (int ch = 0; ch < NCH; ch++) begin
      endAt[ch] = -1;
      endVal[ch] = '0;
      if (mask[ch]) begin
        int nb;
        logic [15:0] ofs;
        logic [1:0] idx;
        int chStart;
        chStart = t;
        nb = (cfgCount[ch] == 16'd0) ? 65536 : int'(cfgCount[ch]);
        if (abortAbs >= 0 && abortMask[ch]) begin
          if (abortAbs < chStart) nb = 0;           // R11 skipped
          else begin
            int lim;
            lim = (abortAbs < chStart + 8) ? 1 : (abortAbs - chStart - 8) / 8 + 1;
            if (lim < nb) nb = lim;
          end
        end
        if (nb > 0) begin
          t += 8;
          ofs = cfgAddr[ch];
          idx = 2'd0;   // R4
          for (int b = 0; b < nb; b++) begin
            item_t e;
            logic [23:0] a24;
            logic [7:0] bb, d;
            a24 = {cfgBank[ch], ofs};
            bb = cfgTarget[ch] + bStep(cfgMode[ch], idx);
            if (!cfgDir[ch]) begin
              d = okA(a24) ? aModel(a24) : 8'h00;
              if (okB(bb, a24)) begin
                e.isB = 1'b1; e.addr = {16'h0021, bb}; e.data = d; e.cyc = t + 7;
                expQ.push_back(e);
              end
            end else begin
              d = okB(bb, a24) ? bModel(bb) : 8'h00;
              if (okA(a24)) begin
                e.isB = 1'b0; e.addr = a24; e.data = d; e.cyc = t + 7;
                expQ.push_back(e);
              end
            end
            if (!cfgFixed[ch]) ofs = cfgReverse[ch] ? ofs - 16'd1 : ofs + 16'd1;
            idx = idx + 2'd1;
            t += 8;
          end
          rem[ch] = 1'b0;
          endAt[ch] = t;
          endVal[ch] = rem;
        end
      end
    end
    tEnd = t;
    start = 1'b1;
    startMask = mask;
    @(negedge clk);
    start = 1'b0;
    startMask = '0;
    // R1 busy rises, R10 enables armed
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (abortAbs < 0 || abortAbs > s)
      check(chanEnable == mask, "R10", "enables armed", chanEnable, mask);
    while (cyc < tEnd) begin
      enableClr = (cyc == abortAbs) ? abortMask : '0;
      if (cyc == tEnd - 1) check(busy == 1'b1, "R1", "busy before end", busy, 1);
      for (int ch = 0; ch < NCH; ch++)
        if (abortAbs < 0 && endAt[ch] == cyc)
          check(chanEnable == endVal[ch], "R10", "enable cleared at finish",
                chanEnable, endVal[ch]);
      @(negedge clk);
    end
    enableClr = '0;
    check(busy == 1'b0, "R1", "busy low at end", busy, 0);
    check(chanEnable == '0, "R10", "all enables clear", chanEnable, 0);
    // R12 start during the low cycle is ignored
    start = 1'b1;
    startMask = '1;
    @(negedge clk);
    start = 1'b0;
    startMask = '0;
    check(busy == 1'b0, "R12", "start ignored while resting", busy, 0);
    check(chanEnable == '0, "R12", "no channel armed while resting", chanEnable, 0);
    check(expQ.size() == 0, "R9/R11", "expected writes left over", expQ.size(), 0);
    expQ.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R1 watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    check(chanEnable == '0, "R10", "reset enables", chanEnable, 0);
    check(!(aRead || aWrite || bRead || bWrite), "R1", "reset strobes", 1, 0);

    // Job A: R2 order, R3 modes 1/4/3, R4, R5 inc/dec/fixed, R6 both directions
    setChan(0, 1'b0, 3'd1, 8'h18, 8'h01, 16'h8000, 1'b0, 1'b0, 16'd6);
    setChan(2, 1'b1, 3'd4, 8'h04, 8'h7E, 16'h1000, 1'b0, 1'b1, 16'd5);
    setChan(5, 1'b0, 3'd3, 8'h40, 8'h02, 16'h9000, 1'b1, 1'b0, 16'd4);
    runJob(8'b0010_0101, -1, '0);

    // Job B: R7 refused regions, R8 work-RAM rule, modes 5/7/2/6
    setChan(0, 1'b1, 3'd0, 8'h10, 8'h80, 16'h437E, 1'b0, 1'b0, 16'd3);
    setChan(1, 1'b0, 3'd5, 8'h22, 8'h00, 16'h20FE, 1'b0, 1'b0, 16'd4);
    setChan(3, 1'b1, 3'd7, 8'h30, 8'h00, 16'h421E, 1'b0, 1'b0, 16'd3);
    setChan(4, 1'b0, 3'd0, 8'h80, 8'h7F, 16'h0010, 1'b0, 1'b0, 16'd2);
    setChan(6, 1'b0, 3'd2, 8'h80, 8'h40, 16'h2100, 1'b0, 1'b0, 16'd2);
    setChan(7, 1'b1, 3'd6, 8'h80, 8'h00, 16'h1FFF, 1'b0, 1'b0, 16'd2);
    runJob(8'b1101_1011, -1, '0);

    // Job C: R9 count 0 keeps going, R11 mid-transfer abort and skipped channel,
    // R5 16-bit wrap with bank held
    setChan(0, 1'b0, 3'd4, 8'h08, 8'h03, 16'hFFFE, 1'b0, 1'b0, 16'd0);
    setChan(1, 1'b1, 3'd0, 8'h11, 8'h00, 16'h41FF, 1'b0, 1'b0, 16'd2);
    setChan(2, 1'b0, 3'd0, 8'h12, 8'h00, 16'h3FFF, 1'b0, 1'b0, 16'd1);
    setChan(4, 1'b0, 3'd0, 8'h14, 8'h05, 16'h0100, 1'b0, 1'b0, 16'd3);
    runJob(8'b0001_0111, 51, 8'b0001_0001);

    // Job D: R11 clear during channel preamble moves one byte
    setChan(3, 1'b0, 3'd1, 8'h50, 8'h06, 16'h0200, 1'b0, 1'b0, 16'd7);
    runJob(8'b0000_1000, 11, 8'b0000_1000);

    // Job E: empty mask, preamble only (R1, R12)
    runJob('0, -1, '0);

    finishRun();
  end
endmodule